// File: doc/BRIEF.md
# Host Command Mailbox with Update-Mode Handshake

This block is the controller-side end of a two-port byte mailbox in the style of a legacy keyboard controller. A host issues writes and reads at two I/O addresses: a command port and a data port. Each direction has a one-byte buffer with a full flag. The host polls those flags through a status byte to pace its traffic. It waits for the input flag to drop before it writes again, and it waits for the output flag to rise before it reads a reply.

Two command codes are decoded. The first moves the controller into a scratch-RAM firmware-update mode and answers with an acknowledge byte. The second returns it to normal execution. A leave request that arrives while the controller is already in normal mode is treated as a request to reset the system, and the block drives a one-cycle reset pulse. Any other written byte is consumed and produces no reply. Consumption of an accepted byte is deliberately delayed by a parameterised number of cycles, which gives the host time to observe the input flag high.

Top module: `kbc_mailbox`

## Requirements
- R1: A host read of the command port (address 0x64) returns the status byte. Bit 1 is the input-full flag, bit 0 is the output-full flag, and bits 7:2 read as zero.
- R2: A host write to the command port or to the data port (0x60) is accepted only while the input-full flag is clear. An accepted write sets the flag. A write that arrives while the flag is set is dropped and never decoded.
- R3: The input-full flag stays set for exactly CONSUME_CYCLES clock cycles after the accepting edge, and then clears (default 4).
- R4: When command 0xB4 is consumed, update_mode goes high and the reply byte 0xFA is placed in the output buffer with the output-full flag set.
- R5: A host read of the data port returns the output buffer and clears the output-full flag at the same clock edge.
- R6: When command 0xFE is consumed in update mode, update_mode goes low, no reply is produced and no reset pulse is issued.
- R7: When command 0xFE is consumed outside update mode, sys_reset_pulse is high for exactly one cycle, no reply is produced, and update_mode stays low.
- R8: Command bytes other than 0xB4 and 0xFE are consumed without a reply and leave update_mode unchanged.
- R9: Bytes written to the data port are consumed after the same delay but are never decoded as commands.
- R10: Writes to any other address are ignored, and reads of any other address return 0x00.
- R11: After synchronous reset, both flags are clear, update_mode and sys_reset_pulse are low, and host_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_addr | input | ADDR_W (8) | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, registered, valid the cycle after host_rd |
| update_mode | output | 1 | High while the controller is in scratch-RAM update mode |
| sys_reset_pulse | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a second write that lands while the first byte is still waiting to be consumed. The only evidence that it was dropped is what the first byte then does. The bench writes 0xB4 and on the very next cycle writes 0xFE. It then shows that the block enters update mode, answers 0xFA and issues no reset. The exact length of the input-full window is measured by holding a status read on every cycle across the consumption edge.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] CMD_ENTER_UPD = 8'hB4;
  localparam logic [7:0] CMD_LEAVE_UPD = 8'hFE;
  localparam logic [7:0] REPLY_ACK     = 8'hFA;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_CMD  = 2'd1,
    PORT_DATA = 2'd2
  } port_sel_e;
endpackage

// File: rtl/kbc_host_port.sv
module kbc_host_port
  import kbc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h64,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              in_full,
  input  logic              reply_load,
  input  logic [7:0]        reply_byte,
  output logic              wr_accept,
  output logic              wr_is_cmd,
  output logic [7:0]        wr_byte,
  output logic              out_full,
  output logic [7:0]        host_rdata
);
  port_sel_e sel;
  logic [7:0] out_buf;
  logic [7:0] status;

  always_comb begin
    if (host_addr == CMD_ADDR)       sel = PORT_CMD;
    else if (host_addr == DATA_ADDR) sel = PORT_DATA;
    else                             sel = PORT_NONE;
  end

  assign wr_accept = host_wr && (sel != PORT_NONE) && !in_full;
  assign wr_is_cmd = (sel == PORT_CMD);
  assign wr_byte   = host_wdata;
  assign status    = {6'b0, in_full, out_full};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_buf    <= 8'h00;
      out_full   <= 1'b0;
      host_rdata <= 8'h00;
    end else begin
      if (host_rd) begin
        case (sel)
          PORT_CMD:  host_rdata <= status;
          PORT_DATA: host_rdata <= out_buf;
          default:   host_rdata <= 8'h00;
        endcase
      end
      if (reply_load) begin
        out_buf  <= reply_byte;
        out_full <= 1'b1;
      end else if (host_rd && sel == PORT_DATA) begin
        out_full <= 1'b0;
      end
    end
  end

  p_status_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (host_rd && sel == PORT_CMD) |=> (host_rdata[7:2] == 6'b0));

  p_rd_clears_full_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rd && sel == PORT_DATA && !reply_load) |=> !out_full);

  p_other_addr_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && sel == PORT_NONE) |=> (host_rdata == 8'h00));
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter int CONSUME_CYCLES = 4,
  localparam int CNT_W = (CONSUME_CYCLES > 1) ? $clog2(CONSUME_CYCLES) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_accept,
  input  logic       wr_is_cmd,
  input  logic [7:0] wr_byte,
  output logic       in_full,
  output logic       reply_load,
  output logic [7:0] reply_byte,
  output logic       update_mode,
  output logic       sys_reset_pulse
);
  logic [7:0]       in_buf;
  logic             in_is_cmd;
  logic [CNT_W-1:0] wait_cnt;
  logic             consume;
  logic             is_enter, is_leave;

  assign consume  = in_full && (wait_cnt == CNT_W'(CONSUME_CYCLES - 1));
  assign is_enter = consume && in_is_cmd && (in_buf == CMD_ENTER_UPD);
  assign is_leave = consume && in_is_cmd && (in_buf == CMD_LEAVE_UPD);

  assign reply_load = is_enter;
  assign reply_byte = REPLY_ACK;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_buf          <= 8'h00;
      in_is_cmd       <= 1'b0;
      in_full         <= 1'b0;
      wait_cnt        <= '0;
      update_mode     <= 1'b0;
      sys_reset_pulse <= 1'b0;
    end else begin
      sys_reset_pulse <= 1'b0;
      if (wr_accept) begin
        in_buf    <= wr_byte;
        in_is_cmd <= wr_is_cmd;
        in_full   <= 1'b1;
        wait_cnt  <= '0;
      end else if (consume) begin
        in_full <= 1'b0;
      end else if (in_full) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
      if (is_enter) begin
        update_mode <= 1'b1;
      end else if (is_leave) begin
        if (update_mode) update_mode <= 1'b0;
        else             sys_reset_pulse <= 1'b1;
      end
    end
  end

  p_no_accept_full_r2: assert property (@(posedge clk) disable iff (rst)
    in_full |-> !wr_accept);

  p_enter_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(update_mode) |-> $past(reply_load));

  p_leave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(update_mode) |-> !sys_reset_pulse);

  p_reset_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    sys_reset_pulse |=> !sys_reset_pulse);

  p_reset_normal_only_r7: assert property (@(posedge clk) disable iff (rst)
    sys_reset_pulse |-> !update_mode);
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h64,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h60,
  parameter int CONSUME_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              update_mode,
  output logic              sys_reset_pulse
);
  logic       in_full, out_full;
  logic       wr_accept, wr_is_cmd;
  logic [7:0] wr_byte;
  logic       reply_load;
  logic [7:0] reply_byte;

  kbc_host_port #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_port (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata),
    .in_full(in_full), .reply_load(reply_load), .reply_byte(reply_byte),
    .wr_accept(wr_accept), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
    .out_full(out_full), .host_rdata(host_rdata)
  );

  kbc_cmd_engine #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_engine (
    .clk(clk), .rst(rst),
    .wr_accept(wr_accept), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
    .in_full(in_full), .reply_load(reply_load), .reply_byte(reply_byte),
    .update_mode(update_mode), .sys_reset_pulse(sys_reset_pulse)
  );

  p_reply_sets_full_r4: assert property (@(posedge clk) disable iff (rst)
    reply_load |=> out_full);
endmodule

// File: tb/tb_kbc_mailbox.sv
module tb_kbc_mailbox;
  localparam int LAT = 4;
  localparam logic [7:0] CMDP = 8'h64;
  localparam logic [7:0] DATP = 8'h60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       update_mode, sys_reset_pulse;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  kbc_mailbox #(.CONSUME_CYCLES(LAT)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .update_mode(update_mode), .sys_reset_pulse(sys_reset_pulse)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic wait_consume();
    repeat (LAT) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R11 rdata", host_rdata, 8'h00);
    check("R11 update_mode", {7'b0, update_mode}, 8'h00);
    check("R11 reset pulse", {7'b0, sys_reset_pulse}, 8'h00);
    do_read(CMDP, v);
    check("R11 status", v, 8'h00);
  endtask

  task automatic t_window();
    do_write(CMDP, 8'h55);
    host_rd = 1'b1; host_addr = CMDP;
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      check("R3 flag high window", host_rdata, 8'h02);
    end
    @(negedge clk);
    check("R3 flag cleared", host_rdata, 8'h00);
    host_rd = 1'b0;
  endtask

  task automatic t_enter();
    logic [7:0] v;
    do_write(CMDP, 8'hB4);
    wait_consume();
    check("R4 update_mode", {7'b0, update_mode}, 8'h01);
    do_read(CMDP, v);
    check("R1 R4 status obf", v, 8'h01);
    do_read(DATP, v);
    check("R5 reply byte", v, 8'hFA);
    do_read(CMDP, v);
    check("R5 obf cleared", v, 8'h00);
  endtask

  task automatic t_leave();
    logic [7:0] v;
    logic seen = 1'b0;
    do_write(CMDP, 8'hFE);
    for (int i = 0; i < LAT + 1; i++) begin
      @(negedge clk);
      if (sys_reset_pulse) seen = 1'b1;
    end
    check("R6 update_mode low", {7'b0, update_mode}, 8'h00);
    check("R6 no reset", {7'b0, seen}, 8'h00);
    do_read(CMDP, v);
    check("R6 no reply", v, 8'h00);
  endtask

  task automatic t_sysreset();
    logic [7:0] v;
    do_write(CMDP, 8'hFE);
    repeat (LAT - 1) @(negedge clk);
    check("R7 not early", {7'b0, sys_reset_pulse}, 8'h00);
    @(negedge clk);
    check("R7 pulse high", {7'b0, sys_reset_pulse}, 8'h01);
    @(negedge clk);
    check("R7 pulse one cycle", {7'b0, sys_reset_pulse}, 8'h00);
    check("R7 mode low", {7'b0, update_mode}, 8'h00);
    do_read(CMDP, v);
    check("R7 no reply", v, 8'h00);
  endtask

  task automatic t_dropped();
    logic [7:0] v;
    logic seen = 1'b0;
    do_write(CMDP, 8'hB4);
    do_write(CMDP, 8'hFE);
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      if (sys_reset_pulse) seen = 1'b1;
    end
    check("R2 first kept", {7'b0, update_mode}, 8'h01);
    check("R2 second dropped", {7'b0, seen}, 8'h00);
    do_read(DATP, v);
    check("R2 reply of first", v, 8'hFA);
    t_leave();
  endtask

  task automatic t_other();
    logic [7:0] v;
    do_write(CMDP, 8'h20);
    wait_consume();
    do_read(CMDP, v);
    check("R8 no reply", v, 8'h00);
    check("R8 mode unchanged", {7'b0, update_mode}, 8'h00);
  endtask

  task automatic t_data_port();
    logic [7:0] v;
    do_write(DATP, 8'hB4);
    do_read(CMDP, v);
    check("R9 data write sets flag", v, 8'h02);
    wait_consume();
    do_read(CMDP, v);
    check("R9 consumed no reply", v, 8'h00);
    check("R9 not decoded", {7'b0, update_mode}, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic [7:0] v;
    do_write(8'h65, 8'hB4);
    do_read(CMDP, v);
    check("R10 write ignored", v, 8'h00);
    wait_consume();
    check("R10 mode unchanged", {7'b0, update_mode}, 8'h00);
    do_read(8'h65, v);
    check("R10 read zero", v, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_window();
    t_enter();
    t_leave();
    t_sysreset();
    t_dropped();
    t_other();
    t_data_port();
    t_bad_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule